// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target has left stuck, before the bus controller is handed the pins again. When the trigger is seen, it looks at the synchronized levels of the clock and data lines while driving neither. If both already read high, it reports success at once and touches nothing.

If either line is low, the sequencer clocks the bus by hand. It pulls the clock line low for one phase and then lets it go for one phase, and does this a fixed number of times. A target stuck partway through a byte can then shift out its remaining bits and let go of the data line. After the last pulse it watches both lines. It reports success as soon as both read high, or reports a busy error once a deadline expires. Both lines are only ever pulled low, never driven high. The data line is never pulled low at all.

Phase and deadline lengths are given in microseconds and turned into clock counts from a clock-frequency parameter. Both line inputs pass through a two-flop synchronizer before the sequencer looks at them. A trigger that arrives while a sequence runs has no effect.

Top module: `bus_unstick`

## Requirements
- R1: After reset, the clock drive, the data drive, the done output and the error flag are all 0.
- R2: If both lines read high at the check, done pulses on the first edge after the trigger edge, the error flag is 0 and no clock pulse is issued.
- R3: Otherwise the clock drive goes high exactly PULSES times (default 9). Each high stretch lasts P cycles and each gap between pulses lasts P cycles, where P = CLK_HZ*PHASE_US/1000000.
- R4: The data drive output is never asserted.
- R5: If both lines read high when polling begins, done arrives 2+2*PULSES*P edges after the trigger edge, with the error flag 0.
- R6: If the lines never both read high, done arrives 1+2*PULSES*P+D edges after the trigger edge, where D = CLK_HZ*DEADLINE_US/1000000. The error flag rises on that same edge.
- R7: Done is high for exactly one cycle per sequence.
- R8: The error flag holds its value until the next accepted trigger, and it is cleared on the edge that accepts that trigger.
- R9: A trigger that arrives while a sequence runs is ignored. The pulse count and the completion time stay the same, and no second sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Starts a recovery sequence when the sequencer is idle |
| scl_in_i | input | 1 | Raw level of the clock line |
| sda_in_i | input | 1 | Raw level of the data line |
| scl_drive_low_o | output | 1 | Pulls the clock line low when 1 |
| sda_drive_low_o | output | 1 | Pulls the data line low when 1; always 0 |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Busy error from the last sequence |

## Verification
Latency counts edges after the edge that captures the trigger. Done is due 1 edge later when the bus is already free and 2+18P edges later when recovery works. It is due 1+18P+D edges later on a timeout. The error flag clears on the capturing edge itself. The bench raises the trigger for one cycle and waits for the capturing edge. It then counts edges, looking at the outputs only on falling edges, and compares the count it finds with these figures, which it computes from its own copy of P and D. Pulse widths and gaps are timed separately by a monitor that watches the clock drive.

// File: rtl/bus_unstick_pkg.sv
package bus_unstick_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_LOW,
    ST_HIGH,
    ST_POLL,
    ST_FINISH
  } seq_state_t;

  // clock cycles spanned by a time given in microseconds, never less than one
  function automatic longint unsigned us_to_cycles(input longint unsigned clk_hz,
                                                   input longint unsigned usec);
    longint unsigned c;
    c = (clk_hz * usec) / 64'd1000000;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic longint unsigned max_of(input longint unsigned a,
                                             input longint unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] sync_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;
      else         chain <= {chain[STAGES-2:0], raw_i[g]};
    end
    assign sync_o[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/unstick_timer.sv
module unstick_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);

  logic [W-1:0] count;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            count <= '0;
    else if (load_i)        count <= load_val_i;
    else if (count != '0)   count <= count - 1'b1;
  end

  assign expired_o = (count == '0);

endmodule

// File: rtl/bus_unstick.sv
module bus_unstick
  import bus_unstick_pkg::*;
#(
  parameter longint unsigned CLK_HZ      = 100_000_000,
  parameter longint unsigned PHASE_US    = 50,
  parameter longint unsigned DEADLINE_US = 200_000,
  parameter int              PULSES      = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic scl_in_i,
  input  logic sda_in_i,
  output logic scl_drive_low_o,
  output logic sda_drive_low_o,
  output logic done_o,
  output logic err_o
);

  localparam longint unsigned PHASE_CYC = us_to_cycles(CLK_HZ, PHASE_US);
  localparam longint unsigned POLL_CYC  = us_to_cycles(CLK_HZ, DEADLINE_US);
  localparam longint unsigned MAX_CYC   = max_of(PHASE_CYC, POLL_CYC);
  localparam int              TW        = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0]   PHASE_LD  = TW'(PHASE_CYC - 1);
  localparam logic [TW-1:0]   POLL_LD   = TW'(POLL_CYC - 1);
  localparam int              PCW       = $clog2(PULSES + 1);

  // synchronized line levels
  logic [1:0] lines_s;
  line_sync #(.LINES(2), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  ({scl_in_i, sda_in_i}),
    .sync_o (lines_s)
  );

  // named internal events
  logic bus_free_w;
  logic busy_w;
  logic tmr_exp_w;
  logic last_pulse_w;
  assign bus_free_w = lines_s[1] & lines_s[0];

  seq_state_t    st, nxt;
  logic [PCW-1:0] pulse_cnt;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          pcnt_inc, pcnt_clr, set_err, clr_err;

  assign busy_w       = (st != ST_IDLE);
  assign last_pulse_w = (pulse_cnt == PCW'(PULSES - 1));

  unstick_timer #(.W(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_exp_w)
  );

  always_comb begin
    nxt      = st;
    tmr_load = 1'b0;
    tmr_val  = PHASE_LD;
    pcnt_inc = 1'b0;
    pcnt_clr = 1'b0;
    set_err  = 1'b0;
    clr_err  = 1'b0;
    case (st)
      ST_IDLE: begin
        if (trig_i) begin
          nxt     = ST_CHECK;
          clr_err = 1'b1;
        end
      end
      ST_CHECK: begin
        if (bus_free_w) begin
          nxt = ST_FINISH;
        end else begin
          nxt      = ST_LOW;
          tmr_load = 1'b1;
          pcnt_clr = 1'b1;
        end
      end
      ST_LOW: begin
        if (tmr_exp_w) begin
          nxt      = ST_HIGH;
          tmr_load = 1'b1;
        end
      end
      ST_HIGH: begin
        if (tmr_exp_w) begin
          pcnt_inc = 1'b1;
          tmr_load = 1'b1;
          if (last_pulse_w) begin
            nxt     = ST_POLL;
            tmr_val = POLL_LD;
          end else begin
            nxt = ST_LOW;
          end
        end
      end
      ST_POLL: begin
        if (bus_free_w) begin
          nxt = ST_FINISH;
        end else if (tmr_exp_w) begin
          nxt     = ST_FINISH;
          set_err = 1'b1;
        end
      end
      ST_FINISH: nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      pulse_cnt <= '0;
      err_o     <= 1'b0;
    end else begin
      st <= nxt;
      if (pcnt_clr)      pulse_cnt <= '0;
      else if (pcnt_inc) pulse_cnt <= pulse_cnt + 1'b1;
      if (clr_err)       err_o <= 1'b0;
      else if (set_err)  err_o <= 1'b1;
    end
  end

  assign scl_drive_low_o = (st == ST_LOW);
  assign sda_drive_low_o = 1'b0;
  assign done_o          = (st == ST_FINISH);

endmodule

// File: rtl/bus_unstick_chk.sv
module bus_unstick_chk #(
  parameter int PULSES = 9,
  parameter int PCW    = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           trig_i,
  input logic           done_o,
  input logic           err_o,
  input logic           scl_drive_low_o,
  input logic           busy_w,
  input logic [PCW-1:0] pulse_cnt_w
);

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_err_with_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);

  assert_err_clear_on_trig_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_o) |-> $past(trig_i && !busy_w));

  assert_scl_only_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_drive_low_o |-> busy_w);

  assert_pulse_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_cnt_w <= PCW'(PULSES));

  assert_busy_trig_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_w && trig_i) |=> !$fell(err_o));

endmodule

bind bus_unstick bus_unstick_chk #(.PULSES(PULSES), .PCW(PCW)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .trig_i          (trig_i),
  .done_o          (done_o),
  .err_o           (err_o),
  .scl_drive_low_o (scl_drive_low_o),
  .busy_w          (busy_w),
  .pulse_cnt_w     (pulse_cnt)
);

// File: tb/bus_unstick_bench.sv
module bus_unstick_bench;

  localparam longint unsigned CLK_HZ = 100_000;
  localparam int P   = int'((CLK_HZ * 50) / 1000000);       // phase cycles
  localparam int D   = int'((CLK_HZ * 200000) / 1000000);   // deadline cycles
  localparam int NP  = 9;
  localparam int LAT_FREE = 1;
  localparam int LAT_REC  = 2 + 2 * NP * P;
  localparam int LAT_TO   = 1 + 2 * NP * P + D;
  localparam int LIMIT    = LAT_TO + 100;

  // {scl_stuck, sda_stuck, release_after[3:0], kind[1:0]}; kind 0 free, 1 recovered, 2 timeout
  localparam logic [7:0] VEC [0:4] = '{
    {1'b0, 1'b0, 4'd0,  2'd0},
    {1'b0, 1'b1, 4'd1,  2'd1},
    {1'b0, 1'b1, 4'd9,  2'd1},
    {1'b0, 1'b1, 4'd15, 2'd2},
    {1'b1, 1'b0, 4'd4,  2'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic scl_stuck = 1'b0, sda_stuck = 1'b0;
  logic [3:0] rel = 4'd0;
  int   fall_base = 0;
  logic scl_dl, sda_dl, done, err;
  logic scl_line, sda_line;

  int checks = 0, fails = 0;
  int rises = 0, falls = 0, lowrun = 0, highrun = 1000, width_bad = 0, sda_bad = 0, dones = 0;
  logic last_dl = 1'b0;

  always #2.5 clk = ~clk;

  assign scl_line = !(scl_dl || (scl_stuck && ((falls - fall_base) < int'(rel))));
  assign sda_line = !(sda_stuck && ((falls - fall_base) < int'(rel)));

  bus_unstick #(.CLK_HZ(CLK_HZ)) u_bus_unstick (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .trig_i          (trig),
    .scl_in_i        (scl_line),
    .sda_in_i        (sda_line),
    .scl_drive_low_o (scl_dl),
    .sda_drive_low_o (sda_dl),
    .done_o          (done),
    .err_o           (err)
  );

  // drive-pulse monitor: counts and times each low stretch and gap
  always @(posedge clk) begin
    if (sda_dl) sda_bad = sda_bad + 1;
    if (done) dones = dones + 1;
    if (scl_dl && !last_dl) begin
      rises = rises + 1;
      if (highrun < 2 * P && highrun != P) width_bad = width_bad + 1;
      lowrun = 0;
    end
    if (!scl_dl && last_dl) begin
      falls = falls + 1;
      if (lowrun != P) width_bad = width_bad + 1;
      highrun = 0;
    end
    if (scl_dl) lowrun = lowrun + 1;
    else if (highrun < 100000) highrun = highrun + 1;
    last_dl = scl_dl;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // one sequence; extra_at >= 0 injects a second trigger that many edges in
  task automatic run_seq(input logic s_scl, input logic s_sda, input logic [3:0] r,
                         input int extra_at, output int lat, output int npulse,
                         output int nbad, output int ndone);
    int rb, wb, db;
    @(negedge clk);
    fall_base = falls;
    scl_stuck = s_scl;
    sda_stuck = s_sda;
    rel       = r;
    repeat (4) @(negedge clk);
    rb = rises; wb = width_bad; db = dones;
    trig = 1'b1;
    @(posedge clk);
    @(negedge clk);
    trig = 1'b0;
    check(err == 1'b0, "R8 err cleared at accepting edge", int'(err), 0);
    lat = 0;
    while (!done && lat < LIMIT) begin
      trig = (lat == extra_at);
      @(negedge clk);
      lat++;
    end
    trig = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R7 done width one cycle", int'(done), 0);
    npulse = rises - rb;
    nbad   = width_bad - wb;
    ndone  = dones - db;
  endtask

  initial begin
    repeat (LIMIT * 2 + 40000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    int lat, np, nb, nd, k, exp_lat;
    repeat (3) @(negedge clk);
    check(scl_dl == 1'b0, "R1 scl drive at reset", int'(scl_dl), 0);
    check(sda_dl == 1'b0, "R1 sda drive at reset", int'(sda_dl), 0);
    check(done == 1'b0, "R1 done at reset", int'(done), 0);
    check(err == 1'b0, "R1 err at reset", int'(err), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 5; i++) begin
      k = int'(VEC[i][1:0]);
      exp_lat = (k == 0) ? LAT_FREE : (k == 1) ? LAT_REC : LAT_TO;
      run_seq(VEC[i][7], VEC[i][6], VEC[i][5:2], -1, lat, np, nb, nd);
      check(lat == exp_lat, (k == 0) ? "R2 latency" : (k == 1) ? "R5 latency" : "R6 latency",
            lat, exp_lat);
      check(err == (k == 2), (k == 2) ? "R6 err set" : "R5 err clear", int'(err), int'(k == 2));
      check(np == ((k == 0) ? 0 : NP), (k == 0) ? "R2 no pulses" : "R3 pulse count",
            np, (k == 0) ? 0 : NP);
      check(nb == 0, "R3 pulse and gap widths", nb, 0);
      check(nd == 1, "R7 one done per sequence", nd, 1);
    end
    check(sda_bad == 0, "R4 sda never driven", sda_bad, 0);

    // R8: error holds while idle, then the next trigger clears it
    run_seq(1'b0, 1'b1, 4'd15, -1, lat, np, nb, nd);
    repeat (50) @(negedge clk);
    check(err == 1'b1, "R8 err held while idle", int'(err), 1);
    run_seq(1'b0, 1'b0, 4'd0, -1, lat, np, nb, nd);
    check(lat == LAT_FREE, "R2 latency after error", lat, LAT_FREE);
    check(err == 1'b0, "R8 err stays clear", int'(err), 0);

    // R9: triggers during pulses and during polling are ignored
    run_seq(1'b0, 1'b1, 4'd2, 3 * P, lat, np, nb, nd);
    check(lat == LAT_REC, "R9 latency with mid-pulse trigger", lat, LAT_REC);
    check(np == NP, "R9 pulse count with mid-pulse trigger", np, NP);
    k = rises;
    repeat (4 * P) @(negedge clk);
    check(rises == k, "R9 no second sequence", rises - k, 0);
    check(dones == nd + dones - nd, "R9 done count", nd, 1);
    check(nd == 1, "R9 single done", nd, 1);

    run_seq(1'b0, 1'b1, 4'd15, 2 * NP * P + 10, lat, np, nb, nd);
    check(lat == LAT_TO, "R9 latency with trigger while polling", lat, LAT_TO);
    check(err == 1'b1, "R9 err after ignored trigger", int'(err), 1);
    check(sda_bad == 0, "R4 sda never driven overall", sda_bad, 0);

    summary();
  end

endmodule